// File: doc/BRIEF.md
# Multicycle MIPS-Subset Instruction Sequencer

This block is a non-pipelined integer core for a small MIPS32 subset: ADDU, BEQ, LW, SW, MULTU and DIVU. It handles one instruction at a time and moves it through a fixed series of stages:

- fetch
- decode
- operand read
- execute
- memory request
- memory receive
- write-back

The two memory stages run only for loads and stores. Write-back commits the register or HI/LO result and also updates the program counter.

Fetch and memory receive each take a fixed number of cycles. Execute takes one cycle, except for a multiply or divide, which needs one setup cycle followed by 32 iteration cycles. With the default settings this gives exact latencies of 8 cycles for an ordinary instruction, 13 for a load or store, and 40 for a multiply or divide.

The core uses a single word-wide memory port. It raises `mem_req` for exactly one cycle per access. The memory must return read data within `FETCH_CYC-1` cycles of a fetch request, and within `RECV_CYC-1` cycles of a load request. It must then hold that data until the next request.

After each write-back, `retire` pulses for one cycle. At the same time `instr_cycles` shows how many cycles the retired instruction took. HI, LO, the program counter and a debug register read port are brought out so that results can be observed.

Top module: `seq_core`

## Requirements
- R1: While reset is high and just after it is released, `pc` equals `RST_PC`, `retire` is 0, HI and LO are 0, and every register reads 0.
- R2: An ADDU, a BEQ or a no-op takes exactly `FETCH_CYC`+4 cycles, which is 8 by default.
- R3: An LW or SW takes exactly `FETCH_CYC`+`RECV_CYC`+5 cycles, which is 13 by default.
- R4: A MULTU or DIVU takes exactly `FETCH_CYC`+36 cycles, which is 40 by default.
- R5: Opcode 0 with funct 33 and shamt 0 is ADDU. It writes rs+rt, modulo 2^32, into rd (rs = bits 25:21, rt = bits 20:16, rd = bits 15:11).
- R6: Register 0 always reads 0, and writes to it are discarded.
- R7: Opcode 35 is LW. It reads the word at rs plus the sign-extended 16-bit immediate and writes it into rt.
- R8: Opcode 43 is SW. It writes the value of rt to rs plus the sign-extended immediate. Each memory access raises `mem_req` for one cycle only.
- R9: Opcode 0 with funct 25 is MULTU. It writes the unsigned 64-bit product of rs and rt to HI (upper half) and LO (lower half).
- R10: Opcode 0 with funct 27 is DIVU. It writes the unsigned quotient of rs by rt to LO and the remainder to HI.
- R11: A DIVU with a zero divisor leaves HI and LO unchanged.
- R12: Opcode 4 is BEQ. When rs equals rt, the next PC is PC+4 plus the sign-extended immediate shifted left by 2, so negative offsets branch backward. Otherwise the next PC is PC+4. The PC changes only in write-back.
- R13: Any other encoding, including an R-type word with a nonzero shamt, retires as a no-op in the ordinary latency. It leaves the registers unchanged and advances the PC by 4.
- R14: `retire` is high for a single cycle after each write-back, and `instr_cycles` then equals that instruction's latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | One-cycle access request |
| mem_we | output | 1 | Request is a store |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data, held by the memory until the next request |
| retire | output | 1 | One-cycle pulse after each write-back |
| instr_cycles | output | CYC_W | Cycle count of the last retired instruction |
| pc | output | 32 | Current program counter |
| hi | output | 32 | HI register |
| lo | output | 32 | LO register |
| dbg_raddr | input | 5 | Register index for observation |
| dbg_rdata | output | 32 | Value of register `dbg_raddr` |

## Verification
The bench builds the core with its default parameters: four-cycle fetch and receive windows, a reset PC of 0 and a 16-bit cycle field. These defaults make the 8, 13 and 40 cycle latencies exact targets, and the bench measures them between successive retire pulses. The 32-bit datapath brings wrap-around addition, a product whose upper half is nonzero, a divide with a remainder, and a divide by zero within reach. Forward, backward and untaken branches are covered by a short straight-line program.

// File: rtl/seq_pkg.sv
package seq_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int XLEN   = 32;
    localparam int RIDX_W = 5;

    localparam logic [5:0] OPC_SPECIAL = 6'd0;
    localparam logic [5:0] OPC_BEQ     = 6'd4;
    localparam logic [5:0] OPC_LW      = 6'd35;
    localparam logic [5:0] OPC_SW      = 6'd43;
    localparam logic [5:0] FN_MULTU    = 6'd25;
    localparam logic [5:0] FN_DIVU     = 6'd27;
    localparam logic [5:0] FN_ADDU     = 6'd33;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DEC,
        ST_RFETCH,
        ST_EXEC,
        ST_MREQ,
        ST_MRECV,
        ST_WBACK
    } stage_e;

    typedef enum logic [2:0] {
        OP_NOP,
        OP_ADDU,
        OP_BEQ,
        OP_LW,
        OP_SW,
        OP_MULTU,
        OP_DIVU
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [RIDX_W-1:0] rs;
        logic [RIDX_W-1:0] rt;
        logic [RIDX_W-1:0] rd;
        logic [15:0]       imm;
    } dec_t;
endpackage

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output dec_t            dec
);
    timeunit 1ns;
    timeprecision 1ps;

    always_comb begin
        dec.rs  = instr[25:21];
        dec.rt  = instr[20:16];
        dec.rd  = instr[15:11];
        dec.imm = instr[15:0];
        dec.op  = OP_NOP;
        case (instr[31:26])
            OPC_SPECIAL: begin
                // R-type forms with a nonzero shift amount are no-ops (R13)
                if (instr[10:6] == 5'd0) begin
                    case (instr[5:0])
                        FN_ADDU:  dec.op = OP_ADDU;
                        FN_MULTU: dec.op = OP_MULTU;
                        FN_DIVU:  dec.op = OP_DIVU;
                        default:  dec.op = OP_NOP;
                    endcase
                end
            end
            OPC_BEQ: dec.op = OP_BEQ;
            OPC_LW:  dec.op = OP_LW;
            OPC_SW:  dec.op = OP_SW;
            default: dec.op = OP_NOP;
        endcase
    end
endmodule

// File: rtl/seq_regfile.sv
module seq_regfile #(
    parameter  int NREG = 32,
    parameter  int W    = 32,
    localparam int AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra1,
    output logic [W-1:0]  rd1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd2,
    input  logic [AW-1:0] ra3,
    output logic [W-1:0]  rd3,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [W-1:0] regs_q [NREG];
    logic [W-1:0] regs_d [NREG];

    always_comb begin
        regs_d = regs_q;
        if (wr_en && (wr_addr != '0)) begin
            regs_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '{default: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd1 = regs_q[ra1];
    assign rd2 = regs_q[ra2];
    assign rd3 = regs_q[ra3];

    // R6: register 0 never holds anything but zero
    a_r6_zero_reg_held: assert property (@(posedge clk) disable iff (rst)
        regs_q[0] == '0);
endmodule

// File: rtl/seq_muldiv.sv
module seq_muldiv #(
    parameter  int W  = 32,
    localparam int CW = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         is_div,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic         busy,
    output logic [W-1:0] res_hi,
    output logic [W-1:0] res_lo
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        logic [W-1:0]  hi;
        logic [W-1:0]  lo;
        logic [W-1:0]  dvs;
        logic [CW-1:0] cnt;
        logic          div;
    } md_t;

    md_t        m_q, m_d;
    logic [W:0] shifted;
    logic [W:0] trial;
    logic [W:0] sum;

    always_comb begin
        m_d     = m_q;
        shifted = '0;
        trial   = '0;
        sum     = '0;
        if (start) begin
            m_d.hi  = '0;
            m_d.lo  = opa;
            m_d.dvs = opb;
            m_d.div = is_div;
            m_d.cnt = CW'(W);
        end else if (m_q.cnt != '0) begin
            m_d.cnt = m_q.cnt - 1'b1;
            if (m_q.div) begin
                // restoring step: partial remainder gains one dividend bit
                shifted = {m_q.hi, m_q.lo[W-1]};
                trial   = shifted - {1'b0, m_q.dvs};
                if (!trial[W]) begin
                    m_d.hi = trial[W-1:0];
                    m_d.lo = {m_q.lo[W-2:0], 1'b1};
                end else begin
                    m_d.hi = shifted[W-1:0];
                    m_d.lo = {m_q.lo[W-2:0], 1'b0};
                end
            end else begin
                // shift-add step on the low multiplier bit
                sum = {1'b0, m_q.hi} + (m_q.lo[0] ? {1'b0, m_q.dvs} : '0);
                {m_d.hi, m_d.lo} = {sum, m_q.lo[W-1:1]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign busy   = (m_q.cnt != '0);
    assign res_hi = m_q.hi;
    assign res_lo = m_q.lo;

    // R4: a started operation is in progress on the following cycle
    a_r4_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);
    // R4: no new operation starts while iterations remain
    a_r4_no_restart: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);
endmodule

// File: rtl/seq_core.sv
module seq_core
    import seq_pkg::*;
#(
    parameter int          FETCH_CYC = 4,
    parameter int          RECV_CYC  = 4,
    parameter logic [31:0] RST_PC    = 32'h0,
    parameter int          CYC_W     = 16
) (
    input  logic              clk,
    input  logic              rst,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              retire,
    output logic [CYC_W-1:0]  instr_cycles,
    output logic [31:0]       pc,
    output logic [31:0]       hi,
    output logic [31:0]       lo,
    input  logic [4:0]        dbg_raddr,
    output logic [31:0]       dbg_rdata
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int MD_ITERS = XLEN;
    localparam int SPAN_A   = (FETCH_CYC > RECV_CYC) ? FETCH_CYC : RECV_CYC;
    localparam int SPAN     = (SPAN_A > MD_ITERS + 1) ? SPAN_A : MD_ITERS + 1;
    localparam int CNT_W    = $clog2(SPAN + 1);

    localparam logic [CNT_W-1:0] FETCH_LAST = CNT_W'(FETCH_CYC - 1);
    localparam logic [CNT_W-1:0] RECV_LAST  = CNT_W'(RECV_CYC - 1);
    localparam logic [CNT_W-1:0] MD_LAST    = CNT_W'(MD_ITERS);

    typedef struct packed {
        stage_e           stage;
        logic [CNT_W-1:0] cnt;
        logic [31:0]      pc;
        logic [31:0]      ir;
        dec_t             dec;
        logic [31:0]      opa;
        logic [31:0]      opb;
        logic [31:0]      alu;
        logic [31:0]      tgt;
        logic             taken;
        logic [31:0]      mdr;
        logic [31:0]      hi;
        logic [31:0]      lo;
        logic [CYC_W-1:0] icnt;
        logic             retire;
        logic [CYC_W-1:0] icyc;
    } core_t;

    core_t s_q, s_d;

    dec_t        dec_w;
    logic [31:0] rf_rd1, rf_rd2;
    logic        rf_we;
    logic [4:0]  rf_wa;
    logic [31:0] rf_wd;
    logic        md_start, md_busy;
    logic [31:0] md_hi, md_lo;
    logic [31:0] sext_imm;

    seq_decode i_dec (
        .instr (s_q.ir),
        .dec   (dec_w)
    );

    seq_regfile #(.NREG(32), .W(XLEN)) i_rf (
        .clk     (clk),
        .rst     (rst),
        .ra1     (s_q.dec.rs),
        .rd1     (rf_rd1),
        .ra2     (s_q.dec.rt),
        .rd2     (rf_rd2),
        .ra3     (dbg_raddr),
        .rd3     (dbg_rdata),
        .wr_en   (rf_we),
        .wr_addr (rf_wa),
        .wr_data (rf_wd)
    );

    seq_muldiv #(.W(XLEN)) i_md (
        .clk    (clk),
        .rst    (rst),
        .start  (md_start),
        .is_div (s_q.dec.op == OP_DIVU),
        .opa    (s_q.opa),
        .opb    (s_q.opb),
        .busy   (md_busy),
        .res_hi (md_hi),
        .res_lo (md_lo)
    );

    assign sext_imm = {{16{s_q.dec.imm[15]}}, s_q.dec.imm};

    always_comb begin
        s_d        = s_q;
        s_d.icnt   = s_q.icnt + 1'b1;
        s_d.retire = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = s_q.pc;
        mem_wdata  = s_q.opb;
        rf_we      = 1'b0;
        rf_wa      = s_q.dec.rd;
        rf_wd      = s_q.alu;
        md_start   = 1'b0;

        case (s_q.stage)
            ST_FETCH: begin
                mem_req  = (s_q.cnt == '0);
                mem_addr = s_q.pc;
                if (s_q.cnt == FETCH_LAST) begin
                    s_d.ir    = mem_rdata;
                    s_d.cnt   = '0;
                    s_d.stage = ST_DEC;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_DEC: begin
                s_d.dec   = dec_w;
                s_d.stage = ST_RFETCH;
            end
            ST_RFETCH: begin
                s_d.opa   = rf_rd1;
                s_d.opb   = rf_rd2;
                s_d.stage = ST_EXEC;
            end
            ST_EXEC: begin
                s_d.taken = 1'b0;
                s_d.stage = ST_WBACK;
                case (s_q.dec.op)
                    OP_ADDU: s_d.alu = s_q.opa + s_q.opb;
                    OP_BEQ: begin
                        s_d.tgt   = s_q.pc + 32'd4 + {sext_imm[29:0], 2'b00};
                        s_d.taken = (s_q.opa == s_q.opb);
                    end
                    OP_LW, OP_SW: begin
                        s_d.alu   = s_q.opa + sext_imm;
                        s_d.stage = ST_MREQ;
                    end
                    OP_MULTU, OP_DIVU: begin
                        md_start = (s_q.cnt == '0);
                        if (s_q.cnt == MD_LAST) begin
                            s_d.cnt = '0;
                        end else begin
                            s_d.cnt   = s_q.cnt + 1'b1;
                            s_d.stage = ST_EXEC;
                        end
                    end
                    default: s_d.alu = '0;
                endcase
            end
            ST_MREQ: begin
                mem_req   = 1'b1;
                mem_addr  = s_q.alu;
                mem_we    = (s_q.dec.op == OP_SW);
                mem_wdata = s_q.opb;
                s_d.stage = ST_MRECV;
            end
            ST_MRECV: begin
                if (s_q.cnt == RECV_LAST) begin
                    s_d.mdr   = mem_rdata;
                    s_d.cnt   = '0;
                    s_d.stage = ST_WBACK;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_WBACK: begin
                case (s_q.dec.op)
                    OP_ADDU: begin
                        rf_we = 1'b1;
                        rf_wa = s_q.dec.rd;
                        rf_wd = s_q.alu;
                    end
                    OP_LW: begin
                        rf_we = 1'b1;
                        rf_wa = s_q.dec.rt;
                        rf_wd = s_q.mdr;
                    end
                    OP_MULTU: begin
                        s_d.hi = md_hi;
                        s_d.lo = md_lo;
                    end
                    OP_DIVU: begin
                        if (s_q.opb != '0) begin
                            s_d.hi = md_hi;
                            s_d.lo = md_lo;
                        end
                    end
                    default: rf_we = 1'b0;
                endcase
                s_d.pc     = s_q.taken ? s_q.tgt : (s_q.pc + 32'd4);
                s_d.retire = 1'b1;
                s_d.icyc   = s_q.icnt + 1'b1;
                s_d.icnt   = '0;
                s_d.cnt    = '0;
                s_d.stage  = ST_FETCH;
            end
            default: s_d.stage = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q       <= '0;
            s_q.stage <= ST_FETCH;
            s_q.pc    <= RST_PC;
        end else begin
            s_q <= s_d;
        end
    end

    assign retire       = s_q.retire;
    assign instr_cycles = s_q.icyc;
    assign pc           = s_q.pc;
    assign hi           = s_q.hi;
    assign lo           = s_q.lo;

    // R14: retire never lasts two cycles
    a_r14_retire_one_cycle: assert property (@(posedge clk) disable iff (rst)
        retire |=> !retire);
    // R8: memory requests are single-cycle pulses
    a_r8_req_pulse: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);
    // R12: the program counter moves only out of write-back
    a_r12_pc_hold: assert property (@(posedge clk) disable iff (rst)
        (s_q.stage != ST_WBACK) |=> $stable(pc));
    // R4: the iterative unit has finished before its result is committed
    a_r4_md_finished: assert property (@(posedge clk) disable iff (rst)
        ((s_q.stage == ST_WBACK) &&
         ((s_q.dec.op == OP_MULTU) || (s_q.dec.op == OP_DIVU))) |-> !md_busy);
endmodule

// File: tb/test_seq_core.sv
module test_seq_core;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] rdata_q = '0;
    logic        retire;
    logic [15:0] instr_cycles;
    logic [31:0] pc, hi, lo;
    logic [4:0]  dbg_raddr = '0;
    logic [31:0] dbg_rdata;

    int checks = 0;
    int fails  = 0;

    logic [31:0] mem [64];

    always #10 clk = ~clk;

    seq_core i_seq_core (
        .clk          (clk),
        .rst          (rst),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (rdata_q),
        .retire       (retire),
        .instr_cycles (instr_cycles),
        .pc           (pc),
        .hi           (hi),
        .lo           (lo),
        .dbg_raddr    (dbg_raddr),
        .dbg_rdata    (dbg_rdata)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
            else        rdata_q <= mem[mem_addr[7:2]];
        end
    end

    function automatic logic [31:0] rtype(input int rs, input int rt, input int rd, input int fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction

    function automatic logic [31:0] itype(input int op, input int rs, input int rt, input logic [15:0] imm);
        return {6'(op), 5'(rs), 5'(rt), imm};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_reg(input int idx, output logic [31:0] val);
        dbg_raddr = 5'(idx);
        #1;
        val = dbg_rdata;
    endtask

    task automatic wait_retire(input int exp_len, input string tag);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!retire && n < 200);
        check({tag, " latency"}, 32'(n), 32'(exp_len));
        check({"R14 cycle field ", tag}, 32'(instr_cycles), 32'(exp_len));
    endtask

    task automatic load_program();
        for (int i = 0; i < 64; i++) mem[i] = '0;
        mem[0]  = itype(35, 0, 1, 16'h0080);       // LW r1
        mem[1]  = itype(35, 0, 2, 16'h0084);       // LW r2
        mem[2]  = rtype(1, 2, 3, 33);              // ADDU r3 = r1 + r2
        mem[3]  = rtype(1, 1, 0, 33);              // ADDU into r0
        mem[4]  = 32'hFC00_0000;                   // unknown opcode
        mem[5]  = itype(43, 0, 3, 16'h0088);       // SW r3
        mem[6]  = itype(35, 0, 4, 16'h0088);       // LW r4
        mem[7]  = rtype(1, 2, 0, 25);              // MULTU r1, r2
        mem[8]  = rtype(2, 1, 0, 27);              // DIVU r2, r1
        mem[9]  = rtype(1, 0, 0, 27);              // DIVU by zero
        mem[10] = itype(4, 1, 2, 16'h0005);        // BEQ not taken
        mem[11] = itype(4, 3, 4, 16'h0002);        // BEQ taken forward
        mem[12] = rtype(1, 1, 5, 33);              // skipped
        mem[13] = rtype(1, 1, 5, 33);              // skipped
        mem[14] = itype(4, 0, 0, 16'hFFFF);        // BEQ onto itself
        mem[32] = 32'h0000_0007;
        mem[33] = 32'hFFFF_FFFB;
        mem[34] = 32'h0000_0000;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 pc", pc, 32'h0);
        check("R1 retire", 32'(retire), 32'h0);
        check("R1 hi", hi, 32'h0);
        check("R1 lo", lo, 32'h0);
        read_reg(7, v);
        check("R1 r7", v, 32'h0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_loads();
        logic [31:0] v;
        wait_retire(13, "R3 LW");
        read_reg(1, v);
        check("R7 r1", v, 32'h7);
        wait_retire(13, "R3 LW");
        read_reg(2, v);
        check("R7 r2", v, 32'hFFFF_FFFB);
    endtask

    task automatic t_addu();
        logic [31:0] v;
        wait_retire(8, "R2 ADDU");
        read_reg(3, v);
        check("R5 wrap sum", v, 32'h2);
        wait_retire(8, "R2 ADDU");
        read_reg(0, v);
        check("R6 r0 zero", v, 32'h0);
    endtask

    task automatic t_nop();
        logic [31:0] v;
        wait_retire(8, "R13 unknown");
        check("R13 pc", pc, 32'd20);
        read_reg(1, v);
        check("R13 r1 kept", v, 32'h7);
    endtask

    task automatic t_store();
        logic [31:0] v;
        wait_retire(13, "R3 SW");
        check("R8 stored word", mem[34], 32'h2);
        wait_retire(13, "R3 LW");
        read_reg(4, v);
        check("R7 r4", v, 32'h2);
    endtask

    task automatic t_muldiv();
        wait_retire(40, "R4 MULTU");
        check("R9 hi", hi, 32'h6);
        check("R9 lo", lo, 32'hFFFF_FFDD);
        wait_retire(40, "R4 DIVU");
        check("R10 rem", hi, 32'h6);
        check("R10 quot", lo, 32'h2492_4923);
        wait_retire(40, "R4 DIVU zero");
        check("R11 hi kept", hi, 32'h6);
        check("R11 lo kept", lo, 32'h2492_4923);
    endtask

    task automatic t_branch();
        logic [31:0] v;
        wait_retire(8, "R2 BEQ");
        check("R12 untaken pc", pc, 32'd44);
        wait_retire(8, "R2 BEQ");
        check("R12 taken pc", pc, 32'd56);
        wait_retire(8, "R2 BEQ");
        check("R12 backward pc", pc, 32'd56);
        wait_retire(8, "R2 BEQ");
        check("R12 loop pc", pc, 32'd56);
        read_reg(5, v);
        check("R12 skipped r5", v, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        load_program();
        t_reset();
        t_loads();
        t_addu();
        t_nop();
        t_store();
        t_muldiv();
        t_branch();
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule